// File: doc/BRIEF.md
# Serial-to-byte receive FIFO

This block gathers a demodulated serial bit stream into bytes and buffers them for a host. Each valid input bit is shifted into an 8-bit register, most significant bit first. When the eighth bit arrives, the assembled byte is written into a 66-entry, byte-wide FIFO on that same clock edge.

A host empties the buffer one byte per read frame. A frame starts when the active-low chip select falls. At that edge the oldest byte is popped into a read data register, which holds it for the rest of the frame. The not-empty flag is sampled only at frame start and then held until chip select rises again. A read that is already under way therefore always completes, even if the FIFO runs dry. The host then decides on another read from the flag it sees after the frame.

Four status outputs report the buffer state: not-empty, full, a sticky overrun flag and a level flag. The level flag compares the stored count against a programmable threshold. A clear strobe resets the overrun flag and flushes the FIFO in the same cycle.

Top module: `rx_byte_fifo`

## Requirements
- R1: Bits with `bit_valid_i` high are assembled most significant bit first. The first bit of a byte lands in bit 7. The byte enters the FIFO at the clock edge that takes its eighth valid bit.
- R2: Bytes leave the FIFO in the order they arrived. The FIFO holds up to 66 bytes.
- R3: `not_empty_o` is low after reset. While chip select is deasserted, it is high after an edge exactly when at least one byte is stored.
- R4: At the chip-select falling edge (`cs_ni` from 1 to 0), the oldest byte is popped into `rd_data_o`. If the FIFO is empty, `rd_data_o` becomes 8'h00. `not_empty_o` takes the post-pop state at that edge and holds it while `cs_ni` stays low.
- R5: `full_o` is high exactly when 66 bytes are stored.
- R6: A byte completed while the FIFO is full, with no pop in the same cycle, is discarded. `overrun_o` is then set and stays set until cleared.
- R7: A cycle with `ovr_clr_i` high clears `overrun_o` and empties the FIFO. A byte completed or a pop requested in that same cycle is dropped.
- R8: `level_o` is high when the stored count exceeds the threshold B and low when the count is B or less. B resets to 15 and is loaded from the 7-bit `thr_i` when `thr_we_i` is high.
- R9: If a byte completes in the same cycle as a frame-start pop while the FIFO is full, the pop is served first. The new byte is stored, and `overrun_o` does not change.
- R10: Reset empties the FIFO, clears the bit counter and the overrun flag, and sets `rd_data_o` to 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | Serial bit qualifier |
| bit_i | input | 1 | Serial data bit |
| cs_ni | input | 1 | Host read frame select, active low |
| ovr_clr_i | input | 1 | Clears overrun flag and flushes FIFO |
| thr_we_i | input | 1 | Threshold load strobe |
| thr_i | input | 7 | Threshold value B |
| rd_data_o | output | 8 | Byte popped at the start of the current frame |
| not_empty_o | output | 1 | FIFO holds data (frame-sampled) |
| full_o | output | 1 | FIFO holds 66 bytes |
| overrun_o | output | 1 | Sticky overrun flag |
| level_o | output | 1 | Stored count above threshold |

## Verification
Every result is due one edge after the stimulus that causes it. The stored count, `full_o`, `level_o` and `overrun_o` change at the edge that takes the eighth bit, the pop or the clear. `rd_data_o` and `not_empty_o` change at the edge that sees chip select fall. Inputs are driven on the falling clock edge, and a reference model advances by one clock edge per cycle. Every output is compared with the model at the next falling edge, so each check samples exactly one register stage after its cause. Directed sequences land the eighth bit on a frame start at full, hold a frame open while bytes arrive, and read from an empty FIFO.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rx_deser.sv
module rx_deser
  import rx_fifo_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bit_valid_i,
  input  logic  bit_i,
  output logic  push_o,
  output byte_t byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0] cnt_q;
  byte_t            sr_q;

  assign push_o = bit_valid_i && (cnt_q == CNT_W'(BYTE_W-1));
  assign byte_o = {sr_q[BYTE_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (bit_valid_i) begin
      sr_q  <= byte_o;
      cnt_q <= push_o ? '0 : cnt_q + 1'b1;
    end
  end

  p_byte_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);
endmodule

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 66,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  byte_t            din_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output byte_t            head_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] count_nxt_o,
  output logic             ovr_o
);
  byte_t            mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             full, wr_ok, rd_ok, ovr_q;

  assign full   = (count_q == CNT_W'(DEPTH));
  assign rd_ok  = pop_i && (count_q != '0) && !flush_i;
  // pop frees a slot first, so a push at full still lands
  assign wr_ok  = push_i && (!full || rd_ok) && !flush_i;
  assign head_o = mem_q[rd_ptr_q];

  always_comb begin
    if (flush_i) count_nxt_o = '0;
    else         count_nxt_o = count_q + CNT_W'(wr_ok) - CNT_W'(rd_ok);
  end

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovr_q    <= 1'b0;
    end else begin
      count_q <= count_nxt_o;
      if (flush_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
        ovr_q    <= 1'b0;
      end else begin
        if (wr_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
        if (rd_ok) rd_ptr_q <= ptr_inc(rd_ptr_q);
        if (push_i && full && !rd_ok) ovr_q <= 1'b1;
      end
    end
  end

  assign count_o = count_q;
  assign ovr_o   = ovr_q;

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_drop_at_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i && !flush_i) |=> (ovr_o && $stable(count_q)));
  p_ovr_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !flush_i) |=> ovr_o);
  p_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0 && !ovr_o));
  p_pop_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && full && !flush_i) |=> ($stable(ovr_o) && full));
endmodule

// File: rtl/rx_status.sv
module rx_status #(
  parameter int unsigned DEPTH   = 66,
  parameter int unsigned CNT_W   = 7,
  parameter int unsigned THR_W   = 7,
  parameter int unsigned THR_RST = 15,
  localparam int unsigned CMP_W  = (CNT_W > THR_W) ? CNT_W : THR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] count_nxt_i,
  input  logic             thr_we_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             cs_fall_o,
  output logic             not_empty_o,
  output logic             full_o,
  output logic             level_o
);
  logic             cs_q, ne_q;
  logic [THR_W-1:0] thr_q;

  assign cs_fall_o = cs_q && !cs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b1;
      ne_q  <= 1'b0;
      thr_q <= THR_W'(THR_RST);
    end else begin
      cs_q <= cs_ni;
      // inside a frame the flag is frozen until chip select rises
      if (cs_ni || cs_q) ne_q <= (count_nxt_i != '0);
      if (thr_we_i) thr_q <= thr_i;
    end
  end

  assign not_empty_o = ne_q;
  assign full_o      = (count_i == CNT_W'(DEPTH));
  assign level_o     = CMP_W'(count_i) > CMP_W'(thr_q);

  p_ne_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_q && !cs_ni) |=> $stable(not_empty_o));
  p_ne_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (not_empty_o == (count_i != '0)));
  p_thr_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_we_i |=> (thr_q == $past(thr_i)));
endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH   = 66,
  parameter int unsigned THR_W   = 7,
  parameter int unsigned THR_RST = 15,
  localparam int unsigned CNT_W  = $clog2(DEPTH+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  input  logic             cs_ni,
  input  logic             ovr_clr_i,
  input  logic             thr_we_i,
  input  logic [THR_W-1:0] thr_i,
  output logic [7:0]       rd_data_o,
  output logic             not_empty_o,
  output logic             full_o,
  output logic             overrun_o,
  output logic             level_o
);
  logic             push, pop, cs_fall;
  byte_t            sr_byte, head, rd_q;
  logic [CNT_W-1:0] count, count_nxt;

  assign pop = cs_fall && (count != '0) && !ovr_clr_i;

  rx_deser i_deser (
    .clk_i, .rst_ni, .bit_valid_i, .bit_i,
    .push_o (push),
    .byte_o (sr_byte)
  );

  rx_fifo_store #(.DEPTH(DEPTH)) i_store (
    .clk_i, .rst_ni,
    .push_i      (push),
    .din_i       (sr_byte),
    .pop_i       (pop),
    .flush_i     (ovr_clr_i),
    .head_o      (head),
    .count_o     (count),
    .count_nxt_o (count_nxt),
    .ovr_o       (overrun_o)
  );

  rx_status #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W), .THR_RST(THR_RST)) i_status (
    .clk_i, .rst_ni, .cs_ni,
    .count_i     (count),
    .count_nxt_i (count_nxt),
    .thr_we_i, .thr_i,
    .cs_fall_o   (cs_fall),
    .not_empty_o,
    .full_o,
    .level_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (cs_fall) rd_q <= pop ? head : '0;
  end

  assign rd_data_o = rd_q;

  p_rd_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_fall |=> $stable(rd_data_o));
endmodule

// File: tb/test_rx_byte_fifo.sv
module test_rx_byte_fifo;
  localparam int DEPTH = 66;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       bit_valid_i = 0, bit_i = 0, cs_ni = 1, ovr_clr_i = 0, thr_we_i = 0;
  logic [6:0] thr_i = '0;
  logic [7:0] rd_data_o;
  logic       not_empty_o, full_o, overrun_o, level_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [7:0] mq[$];
  logic [7:0] m_sr = 0, m_rd = 0;
  int         m_cnt = 0, m_thr = 15;
  bit         m_ovr = 0, m_ne = 0, m_cs_prev = 1;

  rx_byte_fifo i_rx_byte_fifo (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_step();
    bit push, fall, pop;
    logic [7:0] nb;
    push = bit_valid_i && (m_cnt == 7);
    nb   = {m_sr[6:0], bit_i};
    fall = m_cs_prev && !cs_ni;
    pop  = fall && (mq.size() > 0) && !ovr_clr_i;
    if (fall) m_rd = pop ? mq.pop_front() : 8'h00;
    if (ovr_clr_i) begin
      mq.delete();
      m_ovr = 0;
    end else if (push) begin
      if (mq.size() < DEPTH) mq.push_back(nb);
      else m_ovr = 1;
    end
    if (bit_valid_i) begin
      m_sr  = nb;
      m_cnt = (m_cnt + 1) % 8;
    end
    if (cs_ni || m_cs_prev) m_ne = (mq.size() != 0);
    m_cs_prev = cs_ni;
    if (thr_we_i) m_thr = int'(thr_i);
  endfunction

  // one clock: inputs already driven at negedge; compare at next negedge
  task automatic cyc();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    chk("R4 rd_data", rd_data_o, m_rd);
    chk("R3 not_empty", not_empty_o, m_ne);
    chk("R5 full", full_o, mq.size() == DEPTH);
    chk("R6 overrun", overrun_o, m_ovr);
    chk("R8 level", level_o, mq.size() > m_thr);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      bit_valid_i = 1; bit_i = b[i];
      cyc();
    end
    bit_valid_i = 0;
  endtask

  task automatic read_frame(input int hold);
    cs_ni = 0; cyc();
    for (int i = 0; i < hold; i++) cyc();
    cs_ni = 1; cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 rd_data", rd_data_o, 0);
    chk("R10 overrun", overrun_o, 0);
    chk("R3 reset not_empty", not_empty_o, 0);
    chk("R8 reset level", level_o, 0);
    rst_ni = 1;
    cyc();

    // R1 msb-first, R2 ordering
    send_byte(8'hA5);
    chk("R1 byte lands", not_empty_o, 1);
    send_byte(8'h3C);
    read_frame(0);
    chk("R1 msb first", rd_data_o, 8'hA5);
    read_frame(0);
    chk("R2 order", rd_data_o, 8'h3C);
    chk("R3 drained", not_empty_o, 0);

    // R4 empty read returns zero
    read_frame(1);
    chk("R4 empty read", rd_data_o, 8'h00);

    // R8 threshold boundary B=15 -> 16
    for (int i = 0; i < 15; i++) send_byte(8'(i));
    chk("R8 at B", level_o, 0);
    send_byte(8'd15);
    chk("R8 at B+1", level_o, 1);

    // R5 fill to 66, R6 overrun
    for (int i = 16; i < DEPTH; i++) send_byte(8'(i));
    chk("R5 full at 66", full_o, 1);
    send_byte(8'hEE);
    chk("R6 overrun set", overrun_o, 1);
    read_frame(0);
    chk("R6 head kept", rd_data_o, 8'd0);
    chk("R5 not full", full_o, 0);
    chk("R6 sticky", overrun_o, 1);

    // R7 clear flushes
    ovr_clr_i = 1; cyc(); ovr_clr_i = 0;
    chk("R7 overrun cleared", overrun_o, 0);
    chk("R7 flushed", not_empty_o, 0);

    // R9 push and pop coincide at full
    for (int i = 0; i < DEPTH; i++) send_byte(8'(i + 100));
    for (int i = 7; i >= 1; i--) begin
      bit_valid_i = 1; bit_i = 1'b1; cyc();
    end
    bit_i = 1'b0; cs_ni = 0; cyc();
    bit_valid_i = 0; cs_ni = 1; cyc();
    chk("R9 no overrun", overrun_o, 0);
    chk("R9 still full", full_o, 1);
    chk("R9 popped head", rd_data_o, 8'd100);

    // R4 hold: frame empties FIFO, bytes arriving mid-frame leave flag low
    ovr_clr_i = 1; cyc(); ovr_clr_i = 0;
    send_byte(8'h5A);
    cs_ni = 0; cyc();
    chk("R4 post-pop low", not_empty_o, 0);
    send_byte(8'h77);
    chk("R4 held in frame", not_empty_o, 0);
    cs_ni = 1; cyc();
    chk("R4 release", not_empty_o, 1);
    chk("R4 data", rd_data_o, 8'h5A);

    // R8 threshold reprogram
    thr_i = 7'd0; thr_we_i = 1; cyc(); thr_we_i = 0;
    chk("R8 new threshold", level_o, 1);

    // random traffic
    for (int n = 0; n < 6000; n++) begin
      bit_valid_i = ($urandom % 10) < 8;
      bit_i       = $urandom % 2;
      if ($urandom % 5 == 0) cs_ni = ~cs_ni;
      ovr_clr_i   = ($urandom % 400) == 0;
      thr_we_i    = ($urandom % 300) == 0;
      thr_i       = 7'($urandom % 70);
      cyc();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule